// File: doc/BRIEF.md
# Interrupt Entry Priority and Context-Frame Sequencer

This block performs the hardware part of taking an interrupt in a small CPU core. On an acknowledge strobe it samples the interrupt's class, its requested priority and the core's current program counter, flag word, stack pointer and priority level. It then writes a six-byte context frame onto a byte-wide stack memory, one byte per clock. Once the frame is written, it presents the new stack pointer and the new processor priority level together with a one-cycle done pulse.

The new priority level depends on the class of the interrupt. A peripheral request installs its own priority. Special sources (watchdog, non-maskable, oscillation-stop, voltage-detect) have no priority of their own and raise the level to its maximum. Software and address-match interrupts keep the current level. Only the program counter and flag word are saved here. Every other register is left to the handler.

The stack-side write port has no back-pressure: the memory must accept one byte in every cycle that `mem_we` is high. The acknowledge strobe is a plain control input. It is sampled only while `busy` is low, so a core may hold it high until it sees `busy`.

Top module: `irq_entry_seq`

## Requirements
- R1: With class code 0 (peripheral), `ipl_out` in the done cycle equals the `req_prio` sampled at acknowledge.
- R2: With class code 1 (special), `ipl_out` in the done cycle is 7, the all-ones level.
- R3: With class code 2 (software or address match) or the reserved code 3, `ipl_out` in the done cycle equals the `ipl_in` sampled at acknowledge.
- R4: With stack pointer m sampled at acknowledge, the frame at address m-6+k holds, for k = 0..5: PC[7:0], PC[15:8], PC[23:16], 0x00, FLG[7:0], FLG[15:8].
- R5: Writes start in the cycle after the acknowledge edge at address m-1. They take six consecutive cycles with the address falling by one each cycle and end at m-6.
- R6: `done` is high for exactly one cycle, the cycle right after the last write. `sp_out` becomes m-6 and `ipl_out` takes its new value on that same edge, and both hold their values in every other cycle.
- R7: PC, FLG, SP, IPL, class and priority are captured on the acknowledge edge. Input changes during the sequence do not alter the written bytes, the addresses or the final outputs.
- R8: `busy` is high from the cycle after an accepted acknowledge through the done cycle. An acknowledge sampled while `busy` is high is ignored and starts no writes.
- R9: A synchronous active-high reset, applied even mid-sequence, leaves `mem_we`, `busy` and `done` low and `sp_out` and `ipl_out` at zero.
- R10: Frame addresses and `sp_out` wrap modulo 2^ADDR_W when m is below 6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| ack | input | 1 | Interrupt acknowledge strobe |
| irq_class | input | 2 | 0 peripheral, 1 special, 2 software/address match, 3 reserved (keep) |
| req_prio | input | IPL_W (3) | Priority of the acknowledged request |
| pc_in | input | 24 | Current program counter |
| flg_in | input | 16 | Current flag register |
| sp_in | input | ADDR_W (24) | Current stack pointer |
| ipl_in | input | IPL_W (3) | Current processor priority level |
| mem_we | output | 1 | Stack byte write enable |
| mem_addr | output | ADDR_W (24) | Stack byte address |
| mem_wdata | output | 8 | Stack byte data |
| sp_out | output | ADDR_W (24) | Stack pointer after the frame |
| ipl_out | output | IPL_W (3) | Priority level after entry |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle completion pulse |

## Verification
Two events can land in the same cycle: a fresh acknowledge, together with changed PC, FLG, SP and class inputs, and the ongoing frame write or done pulse of an earlier entry. The bench provokes this with noisy entries that hold `ack` high and re-randomise every input in each write cycle and in the done cycle. It then requires every byte, address and final output to match the values captured at the original acknowledge. It also requires that no write begins once the sequence returns to idle.

// File: rtl/irq_entry_pkg.sv
package irq_entry_pkg;

  localparam int PC_W        = 24;
  localparam int FLG_W       = 16;
  localparam int FRAME_BYTES = 6;
  localparam int SLOT_W      = $clog2(FRAME_BYTES);

  typedef enum logic [1:0] {
    CLS_PERIPH  = 2'd0,
    CLS_SPECIAL = 2'd1,
    CLS_SOFT    = 2'd2,
    CLS_RSVD    = 2'd3
  } irq_cls_e;

  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_WRITE = 2'd1,
    PH_DONE  = 2'd2
  } seq_phase_e;

  // Byte stored at offset 'slot' above the new stack pointer.
  function automatic logic [7:0] frame_byte(input int unsigned slot,
                                            input logic [PC_W-1:0] pc,
                                            input logic [FLG_W-1:0] flg);
    logic [7:0] b;
    case (slot)
      0:       b = pc[7:0];
      1:       b = pc[15:8];
      2:       b = pc[23:16];
      4:       b = flg[7:0];
      5:       b = flg[15:8];
      default: b = 8'h00;
    endcase
    return b;
  endfunction

endpackage

// File: rtl/irq_ipl_sel.sv
module irq_ipl_sel
  import irq_entry_pkg::*;
#(
  parameter int IPL_W = 3
) (
  input  irq_cls_e         cls,
  input  logic [IPL_W-1:0] prio,
  input  logic [IPL_W-1:0] cur_ipl,
  output logic [IPL_W-1:0] new_ipl
);

  localparam logic [IPL_W-1:0] IPL_MAX = '1;

  always_comb begin
    unique case (cls)
      CLS_PERIPH:  new_ipl = prio;
      CLS_SPECIAL: new_ipl = IPL_MAX;
      default:     new_ipl = cur_ipl;
    endcase
  end

endmodule

// File: rtl/irq_frame_mux.sv
module irq_frame_mux
  import irq_entry_pkg::*;
#(
  parameter int ADDR_W = 24
) (
  input  logic [PC_W-1:0]   pc,
  input  logic [FLG_W-1:0]  flg,
  input  logic [ADDR_W-1:0] sp_base,
  input  logic [SLOT_W-1:0] slot,
  output logic [ADDR_W-1:0] addr,
  output logic [7:0]        data
);

  localparam logic [ADDR_W-1:0] FRAME_SZ = ADDR_W'(FRAME_BYTES);

  logic [7:0] bytes [FRAME_BYTES];

  for (genvar g = 0; g < FRAME_BYTES; g++) begin : g_slot
    assign bytes[g] = frame_byte(g, pc, flg);
  end

  assign addr = sp_base - FRAME_SZ + ADDR_W'(slot);
  assign data = (int'(slot) < FRAME_BYTES) ? bytes[slot] : 8'h00;

endmodule

// File: rtl/irq_frame_seq.sv
module irq_frame_seq
  import irq_entry_pkg::*;
#(
  parameter int ADDR_W = 24,
  parameter int IPL_W  = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ack,
  input  irq_cls_e          cls_in,
  input  logic [IPL_W-1:0]  prio_in,
  input  logic [PC_W-1:0]   pc_in,
  input  logic [FLG_W-1:0]  flg_in,
  input  logic [ADDR_W-1:0] sp_in,
  input  logic [IPL_W-1:0]  ipl_in,
  input  logic [IPL_W-1:0]  ipl_next,
  output irq_cls_e          cls_q,
  output logic [IPL_W-1:0]  prio_q,
  output logic [IPL_W-1:0]  ipl_q,
  output logic [PC_W-1:0]   pc_q,
  output logic [FLG_W-1:0]  flg_q,
  output logic [ADDR_W-1:0] sp_q,
  output logic [SLOT_W-1:0] slot,
  output logic              writing,
  output logic [ADDR_W-1:0] sp_out,
  output logic [IPL_W-1:0]  ipl_out,
  output logic              busy,
  output logic              done
);

  localparam logic [SLOT_W-1:0] SLOT_TOP = SLOT_W'(FRAME_BYTES - 1);
  localparam logic [ADDR_W-1:0] FRAME_SZ = ADDR_W'(FRAME_BYTES);

  seq_phase_e phase;
  logic       accept;

  assign accept  = ack && (phase == PH_IDLE);
  assign writing = (phase == PH_WRITE);
  assign busy    = (phase != PH_IDLE);
  assign done    = (phase == PH_DONE);

  always_ff @(posedge clk) begin
    if (rst) begin
      phase <= PH_IDLE;
      slot  <= '0;
    end else begin
      unique case (phase)
        PH_IDLE: if (accept) begin
          phase <= PH_WRITE;
          slot  <= SLOT_TOP;
        end
        PH_WRITE: begin
          if (slot == '0) phase <= PH_DONE;
          else            slot  <= slot - 1'b1;
        end
        default: phase <= PH_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cls_q  <= CLS_SOFT;
      prio_q <= '0;
      ipl_q  <= '0;
      pc_q   <= '0;
      flg_q  <= '0;
      sp_q   <= '0;
    end else if (accept) begin
      cls_q  <= cls_in;
      prio_q <= prio_in;
      ipl_q  <= ipl_in;
      pc_q   <= pc_in;
      flg_q  <= flg_in;
      sp_q   <= sp_in;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sp_out  <= '0;
      ipl_out <= '0;
    end else if (writing && slot == '0) begin
      sp_out  <= sp_q - FRAME_SZ;
      ipl_out <= ipl_next;
    end
  end

  AST_WE_INSIDE_BUSY: assert property (@(posedge clk) disable iff (rst)
    writing |-> busy);  // R8
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);  // R6
  AST_DONE_AFTER_WRITE: assert property (@(posedge clk) disable iff (rst)
    done |-> !writing && $past(writing));  // R6
  AST_SP_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!done && !$past(rst)) |-> $stable(sp_out));  // R6
  AST_IPL_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!done && !$past(rst)) |-> $stable(ipl_out));  // R6
  AST_CAPTURE_HELD: assert property (@(posedge clk) disable iff (rst)
    (writing && $past(busy) && !$past(rst)) |-> $stable(pc_q) && $stable(sp_q));  // R7

endmodule

// File: rtl/irq_entry_seq.sv
module irq_entry_seq
  import irq_entry_pkg::*;
#(
  parameter int ADDR_W = 24,
  parameter int IPL_W  = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ack,
  input  logic [1:0]        irq_class,
  input  logic [IPL_W-1:0]  req_prio,
  input  logic [23:0]       pc_in,
  input  logic [15:0]       flg_in,
  input  logic [ADDR_W-1:0] sp_in,
  input  logic [IPL_W-1:0]  ipl_in,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [7:0]        mem_wdata,
  output logic [ADDR_W-1:0] sp_out,
  output logic [IPL_W-1:0]  ipl_out,
  output logic              busy,
  output logic              done
);

  irq_cls_e          cls_q;
  logic [IPL_W-1:0]  prio_q, ipl_q, ipl_next;
  logic [PC_W-1:0]   pc_q;
  logic [FLG_W-1:0]  flg_q;
  logic [ADDR_W-1:0] sp_q;
  logic [SLOT_W-1:0] slot;
  logic              writing;

  irq_frame_seq #(.ADDR_W(ADDR_W), .IPL_W(IPL_W)) u_seq (
    .clk(clk), .rst(rst), .ack(ack),
    .cls_in(irq_cls_e'(irq_class)), .prio_in(req_prio),
    .pc_in(pc_in), .flg_in(flg_in), .sp_in(sp_in), .ipl_in(ipl_in),
    .ipl_next(ipl_next),
    .cls_q(cls_q), .prio_q(prio_q), .ipl_q(ipl_q),
    .pc_q(pc_q), .flg_q(flg_q), .sp_q(sp_q),
    .slot(slot), .writing(writing),
    .sp_out(sp_out), .ipl_out(ipl_out), .busy(busy), .done(done)
  );

  irq_ipl_sel #(.IPL_W(IPL_W)) u_ipl (
    .cls(cls_q), .prio(prio_q), .cur_ipl(ipl_q), .new_ipl(ipl_next)
  );

  irq_frame_mux #(.ADDR_W(ADDR_W)) u_mux (
    .pc(pc_q), .flg(flg_q), .sp_base(sp_q), .slot(slot),
    .addr(mem_addr), .data(mem_wdata)
  );

  assign mem_we = writing;

  AST_ADDR_STEP_DOWN: assert property (@(posedge clk) disable iff (rst)
    (mem_we && $past(mem_we) && !$past(rst)) |-> mem_addr == $past(mem_addr) - 1'b1);  // R5
  AST_PERIPH_PRIO: assert property (@(posedge clk) disable iff (rst)
    (done && cls_q == CLS_PERIPH) |-> ipl_out == prio_q);  // R1
  AST_SPECIAL_MAX: assert property (@(posedge clk) disable iff (rst)
    (done && cls_q == CLS_SPECIAL) |-> ipl_out == '1);  // R2
  AST_KEEP_LEVEL: assert property (@(posedge clk) disable iff (rst)
    (done && (cls_q == CLS_SOFT || cls_q == CLS_RSVD)) |-> ipl_out == ipl_q);  // R3
  AST_PAD_ZERO: assert property (@(posedge clk) disable iff (rst)
    (mem_we && mem_addr == sp_q - ADDR_W'(3)) |-> mem_wdata == 8'h00);  // R4

endmodule

// File: tb/sim_irq_entry_seq.sv
module sim_irq_entry_seq;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        ack = 1'b0;
  logic [1:0]  irq_class = 2'd0;
  logic [2:0]  req_prio = 3'd0;
  logic [23:0] pc_in = '0;
  logic [15:0] flg_in = '0;
  logic [23:0] sp_in = '0;
  logic [2:0]  ipl_in = '0;
  logic        mem_we;
  logic [23:0] mem_addr;
  logic [7:0]  mem_wdata;
  logic [23:0] sp_out;
  logic [2:0]  ipl_out;
  logic        busy, done;

  int total = 0;
  int bad = 0;
  logic [23:0] last_sp = '0;
  logic [2:0]  last_ipl = '0;

  always #10 clk = ~clk;

  irq_entry_seq u0 (
    .clk(clk), .rst(rst), .ack(ack), .irq_class(irq_class), .req_prio(req_prio),
    .pc_in(pc_in), .flg_in(flg_in), .sp_in(sp_in), .ipl_in(ipl_in),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .sp_out(sp_out), .ipl_out(ipl_out), .busy(busy), .done(done)
  );

  function automatic logic [2:0] exp_ipl(input logic [1:0] c, input logic [2:0] p,
                                         input logic [2:0] cur);
    if (c == 2'd0) return p;
    if (c == 2'd1) return 3'd7;
    return cur;
  endfunction

  function automatic logic [7:0] exp_byte(input int off, input logic [23:0] pc,
                                          input logic [15:0] flg);
    case (off)
      0: return pc[7:0];
      1: return pc[15:8];
      2: return pc[23:16];
      4: return flg[7:0];
      5: return flg[15:8];
      default: return 8'h00;
    endcase
  endfunction

  task automatic chk(input logic ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic scramble();
    irq_class = 2'($urandom);
    req_prio  = 3'($urandom);
    pc_in     = 24'($urandom);
    flg_in    = 16'($urandom);
    sp_in     = 24'($urandom);
    ipl_in    = 3'($urandom);
  endtask

  task automatic run_entry(input logic [1:0] c, input logic [2:0] p, input logic [23:0] pc,
                           input logic [15:0] flg, input logic [23:0] sp,
                           input logic [2:0] cur, input bit noisy);
    string rq;
    logic [2:0] ei;
    rq = (c == 2'd0) ? "R1" : (c == 2'd1) ? "R2" : "R3";
    ei = exp_ipl(c, p, cur);
    @(negedge clk);
    irq_class = c; req_prio = p; pc_in = pc; flg_in = flg; sp_in = sp; ipl_in = cur;
    ack = 1'b1;
    for (int k = 0; k < 6; k++) begin
      logic [23:0] ea;
      @(negedge clk);
      if (noisy) scramble(); else ack = 1'b0;
      ea = sp - 24'(k + 1);
      chk(mem_we === 1'b1, "R5 write enable", 32'(mem_we), 1);
      chk(mem_addr === ea, "R5/R10 address", 32'(mem_addr), 32'(ea));
      chk(mem_wdata === exp_byte(5 - k, pc, flg), "R4/R7 data",
          32'(mem_wdata), 32'(exp_byte(5 - k, pc, flg)));
      chk(busy === 1'b1 && done === 1'b0, "R8 busy during writes", {busy, done}, 2);
      chk(sp_out === last_sp && ipl_out === last_ipl, "R6 outputs held",
          32'(sp_out), 32'(last_sp));
    end
    @(negedge clk);
    if (noisy) scramble();
    chk(mem_we === 1'b0, "R5 six writes only", 32'(mem_we), 0);
    chk(done === 1'b1 && busy === 1'b1, "R6/R8 done cycle", {done, busy}, 3);
    chk(sp_out === sp - 24'd6, "R6/R10 new sp", 32'(sp_out), 32'(sp - 24'd6));
    chk(ipl_out === ei, rq, 32'(ipl_out), 32'(ei));
    last_sp = sp - 24'd6;
    last_ipl = ei;
    @(negedge clk);
    ack = 1'b0;
    chk(done === 1'b0 && busy === 1'b0 && mem_we === 1'b0, "R8 ack while busy ignored",
        {done, busy, mem_we}, 0);
    chk(sp_out === last_sp && ipl_out === last_ipl, "R6 hold after done",
        32'(ipl_out), 32'(last_ipl));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    chk(mem_we === 1'b0 && busy === 1'b0 && done === 1'b0, "R9 reset controls",
        {mem_we, busy, done}, 0);
    chk(sp_out === '0 && ipl_out === '0, "R9 reset outputs", 32'(sp_out), 0);
    rst = 1'b0;

    run_entry(2'd0, 3'd5, 24'hABCDEF, 16'h1234, 24'h001000, 3'd2, 1'b0);
    run_entry(2'd1, 3'd1, 24'h010203, 16'hBEEF, 24'h002000, 3'd0, 1'b0);
    run_entry(2'd2, 3'd6, 24'hFFFFFF, 16'hFFFF, 24'h003000, 3'd4, 1'b0);
    run_entry(2'd3, 3'd7, 24'h000000, 16'h0000, 24'h004000, 3'd3, 1'b0);
    run_entry(2'd0, 3'd0, 24'h5A5A5A, 16'hA5A5, 24'h000003, 3'd6, 1'b0);
    run_entry(2'd1, 3'd3, 24'h123456, 16'h789A, 24'h000000, 3'd1, 1'b1);

    // R9: reset in the middle of a frame
    @(negedge clk);
    irq_class = 2'd0; req_prio = 3'd4; sp_in = 24'h008000; ack = 1'b1;
    @(negedge clk); ack = 1'b0;
    @(negedge clk); rst = 1'b1;
    @(negedge clk);
    chk(mem_we === 1'b0 && busy === 1'b0 && done === 1'b0, "R9 mid-frame reset",
        {mem_we, busy, done}, 0);
    chk(sp_out === '0 && ipl_out === '0, "R9 mid-frame reset outputs", 32'(ipl_out), 0);
    rst = 1'b0;
    last_sp = '0;
    last_ipl = '0;

    for (int i = 0; i < 40; i++) begin
      run_entry(2'($urandom), 3'($urandom), 24'($urandom), 16'($urandom),
                24'($urandom), 3'($urandom), 1'($urandom));
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule